// File: doc/BRIEF.md
# Quadrature Phase Tracker

This block turns the two phase signals of an incremental rotary encoder into single-cycle step pulses for a position counter. Both phases are first moved into the system clock domain through a synchronizer chain. No logic is ever clocked by an encoder phase. A two-bit tracker then holds the last position the decoder has accepted. On every clock it compares that tracker with the sampled phase pair. The result is one of four outcomes: no movement, one step up, one step down, or a jump of two positions that cannot happen legally.

The decoder resolves every edge of either phase, which gives four counts per full encoder cycle. A jump of two positions means an edge was missed. Such a jump sets a sticky fault flag, and software or a supervisor clears the flag with a dedicated input. After a jump the tracker takes the new position directly, so counting resumes from there.

While reset is held and for a short priming window after it, the tracker loads the synchronized phases instead of comparing against them. Because of this, whatever level the encoder rests at produces neither a count nor a fault.

Top module: `quad_phase_tracker`

## Requirements
- R1: A change of the phase pair is reported in the clock cycle that follows the (SYNC_STAGES+1)-th rising clock edge after the change. Each report lasts exactly one cycle. The default SYNC_STAGES is 2.
- R2: After reset, whatever constant level the phases hold gives no step pulse and no fault. The first legal move away from that level is counted normally.
- R3: When the sampled pair equals the tracker, inc_en_o, dec_en_o and err_o do not change from their idle values. The pair is written {phase_a_i, phase_b_i}.
- R4: Positions are numbered 0, 1, 2 and 3 for the pairs 00, 01, 11 and 10. When the input position equals the tracker position plus 1 (mod 4), inc_en_o pulses for one cycle.
- R5: When the input position equals the tracker position minus 1 (mod 4), dec_en_o pulses for one cycle.
- R6: When the input position differs from the tracker position by 2, err_o is set and no step pulse is given. The tracker takes the new position, so the next single step from there is counted.
- R7: Once set, err_o stays high until err_clr_i is high at a rising edge. If no new fault is detected at that same edge, err_o then reads low in the following cycle.
- R8: If a fault is detected at the same edge where err_clr_i is high, err_o is set (set wins over clear).
- R9: inc_en_o and dec_en_o are never high in the same cycle.
- R10: Bounce on one phase, with each level held for at least one clock, gives a net count (increments minus decrements) equal to the net position change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| phase_a_i | input | 1 | Encoder phase A, asynchronous |
| phase_b_i | input | 1 | Encoder phase B, asynchronous |
| err_clr_i | input | 1 | Synchronous clear of the sticky fault flag |
| inc_en_o | output | 1 | One-cycle pulse for a step up |
| dec_en_o | output | 1 | One-cycle pulse for a step down |
| err_o | output | 1 | Sticky flag for a two-position jump |

## Verification
Two events can land on the same clock edge: a clear of the fault flag and the detection of a new two-position jump. The bench forces this overlap. It drives a jump, counts the synchronizer delay, and raises err_clr_i for exactly the edge at which the jump is compared. It then expects err_o to read high afterwards. The bench also covers the plain case, where a clear arrives on an edge with no new fault and err_o drops. An exhaustive sweep over all sixteen tracker/input pairs judges the step pulses against positions the bench computes.

// File: rtl/qpt_pkg.sv
package qpt_pkg;

  // Distance from tracker position to input position, modulo 4.
  typedef enum logic [1:0] {
    STEP_HOLD    = 2'd0,
    STEP_UP      = 2'd1,
    STEP_ILLEGAL = 2'd2,
    STEP_DOWN    = 2'd3
  } step_e;

  // Gray pair {a,b} -> position: 00->0, 01->1, 11->2, 10->3
  function automatic logic [1:0] gray_to_pos(input logic [1:0] code);
    return {code[1], code[1] ^ code[0]};
  endfunction

endpackage

// File: rtl/qpt_rst_sync.sv
module qpt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_no = chain_q[STAGES-1];

endmodule

// File: rtl/qpt_sync.sv
module qpt_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  for (genvar w = 0; w < WIDTH; w++) begin : g_bit
    logic [STAGES-1:0] stage_q;
    logic [STAGES-1:0] stage_d;

    if (STAGES == 1) begin : g_single
      always_comb stage_d = async_i[w];
    end else begin : g_multi
      always_comb stage_d = {stage_q[STAGES-2:0], async_i[w]};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q <= '0;
      else         stage_q <= stage_d;
    end

    assign sync_o[w] = stage_q[STAGES-1];
  end

endmodule

// File: rtl/qpt_track.sv
module qpt_track
  import qpt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] code_i,
  output logic       inc_o,
  output logic       dec_o,
  output logic       illegal_o
);

  // Load window long enough for the synchronizer to fill after reset.
  localparam int LOAD_CYC = SYNC_STAGES + 1;
  localparam int CW       = $clog2(LOAD_CYC + 1);
  localparam logic [CW-1:0] LOAD_LAST = CW'(LOAD_CYC);

  logic [CW-1:0] prime_q, prime_d;
  logic          prime_en;
  logic [1:0]    trk_q, trk_d;
  logic          trk_en;
  logic          inc_q, inc_d;
  logic          dec_q, dec_d;
  logic          armed;
  step_e         step;

  always_comb begin
    armed    = (prime_q == LOAD_LAST);
    step     = step_e'(gray_to_pos(code_i) - gray_to_pos(trk_q));
    prime_en = !armed;
    prime_d  = prime_q + 1'b1;
    trk_en   = !armed || (step != STEP_HOLD);
    trk_d    = code_i;
    inc_d    = armed && (step == STEP_UP);
    dec_d    = armed && (step == STEP_DOWN);
    illegal_o = armed && (step == STEP_ILLEGAL);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prime_q <= '0;
      trk_q   <= '0;
      inc_q   <= 1'b0;
      dec_q   <= 1'b0;
    end else begin
      if (prime_en) prime_q <= prime_d;
      if (trk_en)   trk_q   <= trk_d;
      inc_q <= inc_d;
      dec_q <= dec_d;
    end
  end

  assign inc_o = inc_q;
  assign dec_o = dec_q;

  // R9: step pulses are mutually exclusive
  a_r9_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(inc_q && dec_q));

  // R2: no step pulse follows a cycle spent in the load window
  a_r2_quiet_prime: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed |=> (!inc_q && !dec_q));

  // R3: equal pair keeps tracker and gives no pulse
  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && code_i == trk_q) |=> (!inc_q && !dec_q && $stable(trk_q)));

  // R6: a two-position jump resynchronizes the tracker without a pulse
  a_r6_resync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> (trk_q == $past(code_i) && !inc_q && !dec_q));

endmodule

// File: rtl/qpt_fault.sv
module qpt_fault (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic err_o
);

  logic err_q, err_d;

  always_comb begin
    if (set_i)      err_d = 1'b1;
    else if (clr_i) err_d = 1'b0;
    else            err_d = err_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= err_d;
  end

  assign err_o = err_q;

  // R7: flag persists without a clear
  a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !clr_i) |=> err_q);

  // R7: a clear on a quiet edge drops the flag
  a_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !err_q);

  // R8: detection beats a simultaneous clear
  a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> err_q);

endmodule

// File: rtl/quad_phase_tracker.sv
module quad_phase_tracker #(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic phase_a_i,
  input  logic phase_b_i,
  input  logic err_clr_i,
  output logic inc_en_o,
  output logic dec_en_o,
  output logic err_o
);

  logic       rst_n_int;
  logic [1:0] code_sync;
  logic       illegal;

  qpt_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_int)
  );

  qpt_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_int),
    .async_i ({phase_a_i, phase_b_i}),
    .sync_o  (code_sync)
  );

  qpt_track #(.SYNC_STAGES(SYNC_STAGES)) u_track (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_int),
    .code_i    (code_sync),
    .inc_o     (inc_en_o),
    .dec_o     (dec_en_o),
    .illegal_o (illegal)
  );

  qpt_fault u_fault (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .set_i  (illegal),
    .clr_i  (err_clr_i),
    .err_o  (err_o)
  );

endmodule

// File: tb/tb_quad_phase_tracker.sv
module tb_quad_phase_tracker;

  localparam int S = 2;
  localparam time PER = 4ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pa = 1'b0, pb = 1'b0, clr = 1'b0;
  logic inc_en, dec_en, err;

  int n_chk = 0, n_fail = 0;
  int n_inc = 0, n_dec = 0;
  int pos = 0;

  always #(PER/2) clk = ~clk;

  quad_phase_tracker #(.SYNC_STAGES(S)) dut (
    .clk_i(clk), .rst_ni(rst_n), .phase_a_i(pa), .phase_b_i(pb),
    .err_clr_i(clr), .inc_en_o(inc_en), .dec_en_o(dec_en), .err_o(err)
  );

  // pulse monitor, sampled away from the active edge
  int both_seen = 0;
  always @(negedge clk) begin
    if (inc_en) n_inc++;
    if (dec_en) n_dec++;
    if (inc_en && dec_en) both_seen++;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_pos(input int p);
    logic [1:0] q;
    q = 2'(p);
    @(negedge clk);
    pa = q[1];
    pb = q[1] ^ q[0];
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_err();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  initial begin
    #(PER * 150000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int bi, bd, exp_net, d;
    // R2: rest at 11 (position 2) through reset
    pa = 1'b1; pb = 1'b1;
    wait_cyc(4);
    @(negedge clk) rst_n = 1'b1;
    wait_cyc(12);
    check(n_inc == 0 && n_dec == 0, "R2 pulses after reset", n_inc + n_dec, 0);
    check(err == 1'b0, "R2 err after reset", err, 0);
    pos = 2;
    bi = n_inc;
    set_pos(3);
    wait_cyc(6);
    check(n_inc - bi == 1, "R2 first step counted", n_inc - bi, 1);
    pos = 3;

    // Exhaustive sweep of tracker/input pairs: R1 R3 R4 R5 R6
    for (int s = 0; s < 4; s++) begin
      for (int t = 0; t < 4; t++) begin
        set_pos(s);
        wait_cyc(6);
        clear_err();
        wait_cyc(2);
        bi = n_inc; bd = n_dec;
        d = (t - s + 4) % 4;
        set_pos(t);
        for (int k = 0; k < S + 1; k++) @(posedge clk);
        @(negedge clk);
        check(inc_en == (d == 1), "R4 R1 inc at latency", inc_en, d == 1);
        check(dec_en == (d == 3), "R5 R1 dec at latency", dec_en, d == 3);
        check(err == (d == 2), "R6 err at latency", err, d == 2);
        @(negedge clk);
        check(!inc_en && !dec_en, "R1 single-cycle pulse", inc_en + dec_en, 0);
        wait_cyc(6);
        check(n_inc - bi == (d == 1 ? 1 : 0), "R3 R4 inc total", n_inc - bi, d == 1);
        check(n_dec - bd == (d == 3 ? 1 : 0), "R3 R5 dec total", n_dec - bd, d == 3);
        check(err == (d == 2), "R3 R6 err settled", err, d == 2);
        if (d == 2) begin
          // R6 resync: next single step from new position counts up
          bi = n_inc;
          set_pos(t + 1);
          wait_cyc(6);
          check(n_inc - bi == 1, "R6 step after resync", n_inc - bi, 1);
          // R7 sticky
          check(err == 1'b1, "R7 err sticky", err, 1);
        end
      end
    end

    // R7 clear on quiet edge
    set_pos(0); wait_cyc(6); clear_err(); wait_cyc(1);
    set_pos(2); wait_cyc(10);
    check(err == 1'b1, "R7 sticky before clear", err, 1);
    clear_err();
    check(err == 1'b0, "R7 cleared", err, 0);

    // R8: clear coincides with detection of a jump
    set_pos(0);
    wait_cyc(8);
    set_pos(2);
    for (int k = 0; k < S; k++) @(posedge clk);
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
    check(err == 1'b1, "R8 set wins over clear", err, 1);
    wait_cyc(4);
    check(err == 1'b1, "R8 err held", err, 1);
    clear_err();
    wait_cyc(2);

    // R10: bounce on one phase plus a walk, net count from positions
    pos = 2;
    bi = n_inc; bd = n_dec; exp_net = 0;
    for (int r = 0; r < 5; r++) begin
      set_pos(pos + 1);
      set_pos(pos);
    end
    set_pos(pos + 1); pos = pos + 1; exp_net += 1;
    for (int r = 0; r < 11; r++) begin
      pos++; exp_net++; set_pos(pos); @(negedge clk);
    end
    for (int r = 0; r < 4; r++) begin
      pos--; exp_net--; set_pos(pos); @(negedge clk);
    end
    for (int r = 0; r < 6; r++) begin
      set_pos(pos - 1);
      set_pos(pos);
    end
    wait_cyc(8);
    check((n_inc - bi) - (n_dec - bd) == exp_net, "R10 net count",
          (n_inc - bi) - (n_dec - bd), exp_net);
    check(err == 1'b0, "R10 no fault from bounce", err, 0);
    check(both_seen == 0, "R9 never both pulses", both_seen, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule